// File: doc/BRIEF.md
# Eight-bit ALU with condition-code update and branch evaluation

This block is the arithmetic core of a small accumulator processor. Each cycle the decoder gives it an operation code, two byte operands and the current condition-code flags. It returns a low result byte and, for the two wide operations, a high result byte. It also returns the next value of the flags, a mask of the flags that the operation owns, and write enables for the two result bytes. Those enables let the register file drop the result of compare, test and bit-test, which affect only the flags.

The block is purely combinational and has no clock, so there is no stream handshake at its edge. The caller registers whatever it needs. Flags outside the operation's mask pass through from the flag input unchanged. That way the caller can load the flag output every time, whatever the operation.

A separate branch-condition port takes a 4-bit condition code and returns whether the branch is taken. It is evaluated from the same flag input. Instruction decode and register storage belong to the surrounding processor.

Top module: `alu8_cc`

## Requirements
- R1: Add (op 14) and add-with-carry (op 15) form a 9-bit sum of a_i, b_i and, for op 15 only, the carry flag. C is bit 8 of the sum. V is (r7^a7)&(r7^b7). H is r4^a4^b4. N is r7 and Z is set when r is zero. These two are the only operations whose mask includes H.
- R2: Subtract (op 11), subtract-with-carry (op 13) and compare (op 12) form a 9-bit difference a_i - b_i, minus the carry flag for op 13 only. C is bit 8 of the difference (the borrow). V is (r7^a7)&(a7^b7). N and Z come from r. Compare asserts neither write enable.
- R3: Flag vectors are ordered {H,N,Z,V,C} in bits 4..0. Every flag whose ccmask_o bit is 0 appears on cc_o exactly as on cc_i. Single-byte operations write only the low byte (wr_lo_o=1, wr_hi_o=0).
- R4: Negate (op 0) returns 0 - a_i. C is set when the result is nonzero. V is set only for an input of 0x80. N and Z come from the result.
- R5: Complement (op 1) returns ~a_i, forces C=1 and V=0, and sets N and Z from the result.
- R6: The right shifts set Z from the result and C from a_i bit 0, and leave V untouched. Logical shift (op 2) inserts 0 into bit 7 and forces N=0. Rotate (op 3) inserts the carry flag into bit 7. Arithmetic shift (op 4) keeps bit 7.
- R7: Rotate left (op 6) returns {a_i[6:0], C}. It sets C to a7 and V to a7^a6, with N and Z from the result.
- R8: Decrement (op 7) and increment (op 8) add -1 or +1. They set V only for inputs 0x80 and 0x7F respectively, update N and Z, and leave C untouched.
- R9: Test (op 9) sets N and Z from a_i, clears V and writes no result. Clear (op 10) writes 0x00 and sets N=0, Z=1, V=0, C=0.
- R10: AND (op 16), bit test (op 17), XOR (op 18) and OR (op 19) set N and Z from the bitwise result and clear V, leaving C and H untouched. Bit test writes no result.
- R11: Multiply (op 20) writes the 16-bit unsigned product a_i*b_i, with hi_o holding the upper byte and lo_o the lower. Z is set when the whole product is zero and C takes product bit 7. N and V are untouched.
- R12: Sign extend (op 21) writes hi_o as 0xFF when a_i bit 7 is set and 0x00 otherwise, with wr_hi_o=1 and wr_lo_o=0. N is a7, Z is set when a_i is zero, and V is cleared.
- R13: take_o follows cond_i, each odd code being the inverse of the even code below it. The codes are: 0 always, 1 never, 2 HI=!(Z|C), 3 LS=Z|C, 4 !C, 5 C, 6 !Z, 7 Z, 8 !V, 9 V, 10 !N, 11 N, 12 GE=!(N^V), 13 LT=N^V, 14 GT=!((N^V)|Z), 15 LE=(N^V)|Z.
- R14: Operation codes 22 to 31 produce lo_o=hi_o=0, a zero mask, no write enable, and cc_o equal to cc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | DW | First operand (accumulator) |
| b_i | input | DW | Second operand |
| cc_i | input | 5 | Current flags {H,N,Z,V,C} |
| cond_i | input | 4 | Branch condition code |
| lo_o | output | DW | Low result byte |
| hi_o | output | DW | High result byte (multiply, sign extend) |
| cc_o | output | 5 | Next flags {H,N,Z,V,C} |
| ccmask_o | output | 5 | Flags owned by the operation |
| wr_lo_o | output | 1 | Low result should be written |
| wr_hi_o | output | 1 | High result should be written |
| take_o | output | 1 | Branch condition holds |

## Verification
The bench builds the block with its default DW=8. That is the width the flag formulas and bit positions are defined for, and it makes an exhaustive sweep cheap. At that width every operand pair with both carry values is applied to add-with-carry and subtract-with-carry, which covers each carry, borrow, overflow and half-carry boundary. Every branch code is checked against every N, Z, V, C combination. Random vectors over all 32 operation codes, including the unassigned ones, exercise the other operations and the pass-through of flags with random incoming values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [4:0] {
    OP_NEG = 5'd0,  OP_COM = 5'd1,  OP_LSR = 5'd2,  OP_ROR = 5'd3,
    OP_ASR = 5'd4,  OP_RSV5 = 5'd5, OP_ROL = 5'd6,  OP_DEC = 5'd7,
    OP_INC = 5'd8,  OP_TST = 5'd9,  OP_CLR = 5'd10, OP_SUB = 5'd11,
    OP_CMP = 5'd12, OP_SBC = 5'd13, OP_ADD = 5'd14, OP_ADC = 5'd15,
    OP_AND = 5'd16, OP_BIT = 5'd17, OP_EOR = 5'd18, OP_OR  = 5'd19,
    OP_MUL = 5'd20, OP_SEX = 5'd21
  } alu_op_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccf_t;

  localparam int CCW = 5;
endpackage

// File: rtl/alu8_unary.sv
module alu8_unary
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic            cin,
  output logic [DW-1:0]   res,
  output ccf_t            flg,
  output ccf_t            msk,
  output logic            wr
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] r;

  always_comb begin
    r   = '0;
    flg = '0;
    msk = '0;
    wr  = 1'b0;
    unique case (op)
      OP_NEG: begin
        r = '0 - a;
        flg.v = r[MSB] & a[MSB];
        flg.c = |r;
        msk = '{h:1'b0, n:1'b1, z:1'b1, v:1'b1, c:1'b1};
        wr = 1'b1;
      end
      OP_COM: begin
        r = ~a;
        flg.c = 1'b1;
        msk = '{h:1'b0, n:1'b1, z:1'b1, v:1'b1, c:1'b1};
        wr = 1'b1;
      end
      OP_LSR, OP_ROR, OP_ASR: begin
        if (op == OP_LSR)      r = {1'b0, a[MSB:1]};
        else if (op == OP_ROR) r = {cin, a[MSB:1]};
        else                   r = {a[MSB], a[MSB:1]};
        flg.c = a[0];
        msk = '{h:1'b0, n:1'b1, z:1'b1, v:1'b0, c:1'b1};
        wr = 1'b1;
      end
      OP_ROL: begin
        r = {a[MSB-1:0], cin};
        flg.c = a[MSB];
        flg.v = a[MSB] ^ a[MSB-1];
        msk = '{h:1'b0, n:1'b1, z:1'b1, v:1'b1, c:1'b1};
        wr = 1'b1;
      end
      OP_DEC: begin
        r = a - 1'b1;
        flg.v = (r[MSB] ^ a[MSB]) & a[MSB];
        msk = '{h:1'b0, n:1'b1, z:1'b1, v:1'b1, c:1'b0};
        wr = 1'b1;
      end
      OP_INC: begin
        r = a + 1'b1;
        flg.v = (r[MSB] ^ a[MSB]) & r[MSB];
        msk = '{h:1'b0, n:1'b1, z:1'b1, v:1'b1, c:1'b0};
        wr = 1'b1;
      end
      OP_TST: begin
        r = a;
        msk = '{h:1'b0, n:1'b1, z:1'b1, v:1'b1, c:1'b0};
      end
      OP_CLR: begin
        r = '0;
        msk = '{h:1'b0, n:1'b1, z:1'b1, v:1'b1, c:1'b1};
        wr = 1'b1;
      end
      default: ;
    endcase
    if (msk.n) begin
      flg.n = r[MSB];
      flg.z = (r == '0);
    end
    res = r;
  end
endmodule

// File: rtl/alu8_binary.sv
module alu8_binary
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            cin,
  output logic [DW-1:0]   res,
  output ccf_t            flg,
  output ccf_t            msk,
  output logic            wr
);
  localparam int MSB = DW - 1;
  localparam int HB  = DW / 2;

  logic [DW:0]   sum_x;
  logic [DW:0]   dif_x;
  logic          add_cy;
  logic          sub_cy;
  logic [DW-1:0] r;

  assign add_cy = (op == OP_ADC) & cin;
  assign sub_cy = (op == OP_SBC) & cin;
  assign sum_x  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, add_cy};
  assign dif_x  = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, sub_cy};

  always_comb begin
    r   = '0;
    flg = '0;
    msk = '0;
    wr  = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        r = sum_x[DW-1:0];
        flg.c = sum_x[DW];
        flg.v = (r[MSB] ^ a[MSB]) & (r[MSB] ^ b[MSB]);
        flg.h = r[HB] ^ a[HB] ^ b[HB];
        msk = '1;
        wr = 1'b1;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        r = dif_x[DW-1:0];
        flg.c = dif_x[DW];
        flg.v = (r[MSB] ^ a[MSB]) & (a[MSB] ^ b[MSB]);
        msk = '{h:1'b0, n:1'b1, z:1'b1, v:1'b1, c:1'b1};
        wr = (op != OP_CMP);
      end
      OP_AND, OP_BIT, OP_EOR, OP_OR: begin
        if (op == OP_EOR)     r = a ^ b;
        else if (op == OP_OR) r = a | b;
        else                  r = a & b;
        msk = '{h:1'b0, n:1'b1, z:1'b1, v:1'b1, c:1'b0};
        wr = (op != OP_BIT);
      end
      default: ;
    endcase
    if (msk.n) begin
      flg.n = r[MSB];
      flg.z = (r == '0);
    end
    res = r;
  end
endmodule

// File: rtl/alu8_wide.sv
module alu8_wide
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   lo,
  output logic [DW-1:0]   hi,
  output ccf_t            flg,
  output ccf_t            msk,
  output logic            wr_lo,
  output logic            wr_hi
);
  localparam int MSB = DW - 1;
  localparam int PW  = 2 * DW;

  logic [PW-1:0] prod;

  assign prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};

  always_comb begin
    lo    = '0;
    hi    = '0;
    flg   = '0;
    msk   = '0;
    wr_lo = 1'b0;
    wr_hi = 1'b0;
    if (op == OP_MUL) begin
      {hi, lo} = prod;
      flg.z = (prod == '0);
      flg.c = prod[MSB];
      msk   = '{h:1'b0, n:1'b0, z:1'b1, v:1'b0, c:1'b1};
      wr_lo = 1'b1;
      wr_hi = 1'b1;
    end else if (op == OP_SEX) begin
      lo    = a;
      hi    = {DW{a[MSB]}};
      flg.n = a[MSB];
      flg.z = (a == '0);
      msk   = '{h:1'b0, n:1'b1, z:1'b1, v:1'b1, c:1'b0};
      wr_hi = 1'b1;
    end
  end
endmodule

// File: rtl/alu8_branch.sv
module alu8_branch #(
  parameter int NCOND = 16
) (
  input  logic [$clog2(NCOND)-1:0] cond,
  input  logic                     n,
  input  logic                     z,
  input  logic                     v,
  input  logic                     c,
  output logic                     take
);
  localparam int NBASE = NCOND / 2;

  logic [NBASE-1:0] base;

  always_comb begin
    base    = '0;
    base[0] = 1'b1;
    base[1] = ~(z | c);
    base[2] = ~c;
    base[3] = ~z;
    base[4] = ~v;
    base[5] = ~n;
    base[6] = ~(n ^ v);
    base[7] = ~((n ^ v) | z);
  end

  assign take = base[cond[$clog2(NCOND)-1:1]] ^ cond[0];
endmodule

// File: rtl/alu8_cc.sv
module alu8_cc
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [4:0]    cc_i,
  input  logic [3:0]    cond_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o,
  output logic [4:0]    cc_o,
  output logic [4:0]    ccmask_o,
  output logic          wr_lo_o,
  output logic          wr_hi_o,
  output logic          take_o
);
  alu_op_e       op_e;
  ccf_t          cc_in;
  logic [DW-1:0] u_res, b_res, w_lo, w_hi;
  ccf_t          u_flg, u_msk, b_flg, b_msk, w_flg, w_msk;
  logic          u_wr, b_wr, w_wrl, w_wrh;
  logic [4:0]    new_flg;

  assign op_e  = alu_op_e'(op_i);
  assign cc_in = ccf_t'(cc_i);

  alu8_unary #(.DW(DW)) u_unary (
    .op(op_e), .a(a_i), .cin(cc_in.c),
    .res(u_res), .flg(u_flg), .msk(u_msk), .wr(u_wr)
  );

  alu8_binary #(.DW(DW)) u_binary (
    .op(op_e), .a(a_i), .b(b_i), .cin(cc_in.c),
    .res(b_res), .flg(b_flg), .msk(b_msk), .wr(b_wr)
  );

  alu8_wide #(.DW(DW)) u_wide (
    .op(op_e), .a(a_i), .b(b_i),
    .lo(w_lo), .hi(w_hi), .flg(w_flg), .msk(w_msk),
    .wr_lo(w_wrl), .wr_hi(w_wrh)
  );

  alu8_branch #(.NCOND(16)) u_branch (
    .cond(cond_i), .n(cc_in.n), .z(cc_in.z), .v(cc_in.v), .c(cc_in.c),
    .take(take_o)
  );

  // Each unit drives zeros outside its own operation group.
  assign lo_o     = u_res | b_res | w_lo;
  assign hi_o     = w_hi;
  assign ccmask_o = u_msk | b_msk | w_msk;
  assign new_flg  = u_flg | b_flg | w_flg;
  assign wr_lo_o  = u_wr | b_wr | w_wrl;
  assign wr_hi_o  = w_wrh;
  assign cc_o     = (new_flg & ccmask_o) | (cc_i & ~ccmask_o);
endmodule

// File: rtl/alu8_cc_chk.sv
module alu8_cc_chk #(
  parameter int DW = 8
) (
  input logic [4:0]    op_i,
  input logic [DW-1:0] a_i,
  input logic [4:0]    cc_i,
  input logic [3:0]    cond_i,
  input logic [DW-1:0] lo_o,
  input logic [DW-1:0] hi_o,
  input logic [4:0]    cc_o,
  input logic [4:0]    ccmask_o,
  input logic          wr_lo_o,
  input logic          wr_hi_o,
  input logic          take_o
);
  localparam int MSB = DW - 1;

  logic known;
  assign known = !$isunknown({op_i, a_i, cc_i, cond_i});

  always_comb begin
    if (known) begin
      assert_keep_flags_R3: assert (((cc_o ^ cc_i) & ~ccmask_o) == 5'b0);
      assert_h_only_add_R1: assert (!ccmask_o[4] || op_i == 5'd14 || op_i == 5'd15);
      assert_cmp_nowrite_R2: assert (op_i != 5'd12 || (!wr_lo_o && !wr_hi_o));
      assert_neg_carry_R4: assert (op_i != 5'd0 || cc_o[0] == (lo_o != '0));
      assert_com_flags_R5: assert (op_i != 5'd1 || (cc_o[0] && !cc_o[1]));
      assert_lsr_nflag_R6: assert (op_i != 5'd2 || !cc_o[3]);
      assert_clr_zero_R9: assert (op_i != 5'd10 || (lo_o == '0 && cc_o[2:0] == 3'b100));
      assert_logic_v_R10: assert (!(op_i >= 5'd16 && op_i <= 5'd19) || !cc_o[1]);
      assert_mul_flags_R11: assert (op_i != 5'd20 ||
                                    (cc_o[2] == ({hi_o, lo_o} == '0) && cc_o[0] == lo_o[MSB]));
      assert_sex_fill_R12: assert (op_i != 5'd21 || hi_o == {DW{a_i[MSB]}});
      assert_branch_fixed_R13: assert ((cond_i != 4'd0 || take_o) && (cond_i != 4'd1 || !take_o));
      assert_unassigned_R14: assert (op_i <= 5'd21 ||
                                     (ccmask_o == 5'b0 && !wr_lo_o && !wr_hi_o));
    end
  end
endmodule

bind alu8_cc alu8_cc_chk #(.DW(DW)) u_chk (
  .op_i(op_i), .a_i(a_i), .cc_i(cc_i), .cond_i(cond_i),
  .lo_o(lo_o), .hi_o(hi_o), .cc_o(cc_o), .ccmask_o(ccmask_o),
  .wr_lo_o(wr_lo_o), .wr_hi_o(wr_hi_o), .take_o(take_o)
);

// File: tb/test_alu8_cc.sv
module test_alu8_cc;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic [4:0] cc_i = '0;
  logic [3:0] cond_i = '0;
  logic [7:0] lo_o, hi_o;
  logic [4:0] cc_o, ccmask_o;
  logic       wr_lo_o, wr_hi_o, take_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_cc #(.DW(8)) i_alu8_cc (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .cc_i(cc_i), .cond_i(cond_i),
    .lo_o(lo_o), .hi_o(hi_o), .cc_o(cc_o), .ccmask_o(ccmask_o),
    .wr_lo_o(wr_lo_o), .wr_hi_o(wr_hi_o), .take_o(take_o)
  );

  typedef struct packed {
    logic [7:0] lo;
    logic [7:0] hi;
    logic [4:0] cc;
    logic [4:0] m;
    logic       wl;
    logic       wh;
  } exp_t;

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'd0: return "R4";
      5'd1: return "R5";
      5'd2, 5'd3, 5'd4: return "R6";
      5'd6: return "R7";
      5'd7, 5'd8: return "R8";
      5'd9, 5'd10: return "R9";
      5'd11, 5'd12, 5'd13: return "R2";
      5'd14, 5'd15: return "R1";
      5'd16, 5'd17, 5'd18, 5'd19: return "R10";
      5'd20: return "R11";
      5'd21: return "R12";
      default: return "R14";
    endcase
  endfunction

  // Reference model; flags {H,N,Z,V,C}
  function automatic exp_t model(input logic [4:0] op, input logic [7:0] a,
                                 input logic [7:0] b, input logic [4:0] cc);
    exp_t e;
    logic h, n, z, v, c;
    logic [8:0] w;
    logic [15:0] p;
    logic [7:0] r;
    logic ci;
    ci = cc[0];
    h = cc[4]; n = cc[3]; z = cc[2]; v = cc[1]; c = cc[0];
    e = '0;
    r = 8'h00;
    case (op)
      5'd0: begin r = 8'h00 - a; v = (a == 8'h80); c = (a != 0); e.m = 5'b01111; end
      5'd1: begin r = ~a; v = 0; c = 1; e.m = 5'b01111; end
      5'd2: begin r = a >> 1; c = a[0]; e.m = 5'b01101; end
      5'd3: begin r = {ci, a[7:1]}; c = a[0]; e.m = 5'b01101; end
      5'd4: begin r = {a[7], a[7:1]}; c = a[0]; e.m = 5'b01101; end
      5'd6: begin r = {a[6:0], ci}; c = a[7]; v = a[7] ^ a[6]; e.m = 5'b01111; end
      5'd7: begin r = a - 8'd1; v = (a == 8'h80); e.m = 5'b01110; end
      5'd8: begin r = a + 8'd1; v = (a == 8'h7F); e.m = 5'b01110; end
      5'd9: begin r = a; v = 0; e.m = 5'b01110; end
      5'd10: begin r = 8'h00; v = 0; c = 0; e.m = 5'b01111; end
      5'd11, 5'd12, 5'd13: begin
        w = {1'b0, a} - {1'b0, b} - ((op == 5'd13) ? 9'(ci) : 9'd0);
        r = w[7:0]; c = w[8];
        v = (a[7] != b[7]) && (r[7] != a[7]);
        e.m = 5'b01111;
      end
      5'd14, 5'd15: begin
        w = {1'b0, a} + {1'b0, b} + ((op == 5'd15) ? 9'(ci) : 9'd0);
        r = w[7:0]; c = w[8];
        v = (a[7] == b[7]) && (r[7] != a[7]);
        h = r[4] ^ a[4] ^ b[4];
        e.m = 5'b11111;
      end
      5'd16, 5'd17: begin r = a & b; v = 0; e.m = 5'b01110; end
      5'd18: begin r = a ^ b; v = 0; e.m = 5'b01110; end
      5'd19: begin r = a | b; v = 0; e.m = 5'b01110; end
      default: ;
    endcase
    if (e.m[3]) begin n = r[7]; z = (r == 8'h00); end
    e.lo = r;
    e.wl = (e.m != 0) && op != 5'd9 && op != 5'd12 && op != 5'd17;
    if (op == 5'd20) begin
      p = 16'(a) * 16'(b);
      {e.hi, e.lo} = p;
      z = (p == 16'h0); c = p[7];
      e.m = 5'b00101; e.wl = 1; e.wh = 1;
    end else if (op == 5'd21) begin
      e.lo = a; e.hi = a[7] ? 8'hFF : 8'h00;
      n = a[7]; z = (a == 8'h00); v = 0;
      e.m = 5'b01110; e.wl = 0; e.wh = 1;
    end
    e.cc = {h, n, z, v, c};
    return e;
  endfunction

  function automatic logic br_model(input logic [3:0] cd, input logic [4:0] cc);
    logic n, z, v, c, t;
    n = cc[3]; z = cc[2]; v = cc[1]; c = cc[0];
    case (cd)
      4'd0: t = 1;            4'd1: t = 0;
      4'd2: t = !(z || c);    4'd3: t = z || c;
      4'd4: t = !c;           4'd5: t = c;
      4'd6: t = !z;           4'd7: t = z;
      4'd8: t = !v;           4'd9: t = v;
      4'd10: t = !n;          4'd11: t = n;
      4'd12: t = (n == v);    4'd13: t = (n != v);
      4'd14: t = (n == v) && !z;
      default: t = (n != v) || z;
    endcase
    return t;
  endfunction

  task automatic run_vec(input logic [4:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [4:0] cc);
    exp_t e;
    bit bad;
    bit unas;
    op_i = op; a_i = a; b_i = b; cc_i = cc;
    #1;
    e = model(op, a, b, cc);
    unas = (op > 5'd21) || (op == 5'd5);
    bad = (cc_o !== e.cc) || (ccmask_o !== e.m) || (wr_lo_o !== e.wl) || (wr_hi_o !== e.wh);
    if ((e.wl || unas) && lo_o !== e.lo) bad = 1;
    if ((e.wh || unas) && hi_o !== e.hi) bad = 1;
    n_tests++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h cc=%b: got lo=%h hi=%h cc=%b m=%b w=%b%b exp lo=%h hi=%h cc=%b m=%b w=%b%b",
               tag_of(op), op, a, b, cc, lo_o, hi_o, cc_o, ccmask_o, wr_lo_o, wr_hi_o,
               e.lo, e.hi, e.cc, e.m, e.wl, e.wh);
    end
  endtask

  task automatic run_br(input logic [3:0] cd, input logic [4:0] cc);
    logic t;
    cond_i = cd; cc_i = cc;
    #1;
    t = br_model(cd, cc);
    n_tests++;
    if (take_o !== t) begin
      n_fail++;
      $display("FAIL R13 cond=%0d cc=%b: got take=%b exp %b", cd, cc, take_o, t);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    s = $urandom(32'd12345);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Post-reset state: all-zero inputs (negate of zero, R4)
    run_vec(5'd0, 8'h00, 8'h00, 5'b00000);

    // Directed corners
    run_vec(5'd0, 8'h80, 8'h00, 5'b00000);   // R4 overflow
    run_vec(5'd0, 8'h01, 8'h00, 5'b11111);   // R4
    run_vec(5'd1, 8'h00, 8'h00, 5'b00010);   // R5
    run_vec(5'd2, 8'h81, 8'h00, 5'b01010);   // R6 N forced, V kept
    run_vec(5'd3, 8'h00, 8'h00, 5'b00001);   // R6 carry into bit 7
    run_vec(5'd4, 8'h80, 8'h00, 5'b00000);   // R6 sign kept
    run_vec(5'd6, 8'h40, 8'h00, 5'b00001);   // R7
    run_vec(5'd8, 8'h7F, 8'h00, 5'b00001);   // R8
    run_vec(5'd7, 8'h80, 8'h00, 5'b00000);   // R8
    run_vec(5'd7, 8'h00, 8'h00, 5'b00000);   // R8 C untouched
    run_vec(5'd9, 8'h00, 8'h00, 5'b00011);   // R9
    run_vec(5'd10, 8'h5A, 8'h00, 5'b11011);  // R9
    run_vec(5'd14, 8'h0F, 8'h01, 5'b00000);  // R1 half carry
    run_vec(5'd14, 8'h7F, 8'h01, 5'b00000);  // R1 overflow
    run_vec(5'd11, 8'h00, 8'h01, 5'b00000);  // R2 borrow
    run_vec(5'd12, 8'h80, 8'h01, 5'b00000);  // R2 overflow, no write
    run_vec(5'd17, 8'hF0, 8'h0F, 5'b10001);  // R10 bit test zero
    run_vec(5'd20, 8'hFF, 8'hFF, 5'b01010);  // R11
    run_vec(5'd20, 8'h00, 8'h37, 5'b00000);  // R11 zero product
    run_vec(5'd20, 8'h10, 8'h08, 5'b00000);  // R11 bit 7 carry
    run_vec(5'd21, 8'h80, 8'h00, 5'b00010);  // R12
    run_vec(5'd21, 8'h00, 8'h00, 5'b01000);  // R12
    run_vec(5'd31, 8'hAA, 8'h55, 5'b10101);  // R14
    run_vec(5'd5, 8'hAA, 8'h55, 5'b01010);   // R14 gap code

    // Exhaustive add-with-carry (R1) and subtract-with-carry (R2); R3 pass-through
    for (int ci = 0; ci < 2; ci++)
      for (int ia = 0; ia < 256; ia++)
        for (int ib = 0; ib < 256; ib++) begin
          run_vec(5'd15, 8'(ia), 8'(ib), {4'($urandom), 1'(ci)});
          run_vec(5'd13, 8'(ia), 8'(ib), {4'($urandom), 1'(ci)});
        end

    // Branch conditions (R13): every code against every N,Z,V,C and H value
    for (int cd = 0; cd < 16; cd++)
      for (int f = 0; f < 32; f++)
        run_br(4'(cd), 5'(f));

    // Random mix over all codes (R3 and the rest)
    for (int k = 0; k < 30000; k++)
      run_vec(5'($urandom), 8'($urandom), 8'($urandom), 5'($urandom));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule